// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block supervises a combined power-factor-correction stage and a three-phase inverter. It takes three already-synchronised comparator flags: an inverter overcurrent flag, a PFC overcurrent flag, and a supply monitor that reports two levels, one for "above the upper threshold" and one for "below the lower threshold". From these it drives a shared active-low fault pin, modelled as an output enable plus the pin level. It also drives a global gate shutdown for the inverter and a separate shutdown for the PFC switch.

A PFC trip must be present for a run of consecutive clocks before it counts. The inverter trip has no filter and cuts the inverter gates on the next clock. Either accepted trip passes through a fixed propagation delay before it latches the fault. A lost supply latches the fault directly. Once every cause has gone, the fault stays on for a clearance period. Any cause that returns during that period starts the clearance again from zero. After reset the block is faulted, and it stays faulted until the supply has been qualified for one full clearance period. All times are counted in clock cycles through parameters.

Top module: `pwr_fault_sup`

## Requirements
- R1: After reset the block is faulted: `flt_oe_o`=1, `flt_n_o`=0, `gate_off_o`=1, `pfc_off_o`=1. It stays so while the supply is unqualified, and releases exactly `CLR_CYC` clocks after the clock that first samples `uv_rise_i`=1.
- R2: The supply state is set by a sampled `uv_rise_i`=1 and cleared by a sampled `uv_fall_i`=1. `uv_fall_i` wins when both are 1. With both at 0 the state holds. A cleared supply state asserts the fault two clocks after `uv_fall_i` is sampled.
- R3: A PFC trip is accepted only when `pfc_oc_i` is sampled 1 on `BLANK_CYC` consecutive clocks. Shorter or interrupted runs change no output.
- R4: `pfc_off_o` rises on the clock that samples the `BLANK_CYC`-th consecutive 1 of `pfc_oc_i`, with no fault yet and `gate_off_o` unaffected. It stays 1 while the trip stays accepted.
- R5: With no fault latched, `gate_off_o` follows `inv_oc_i` with one clock of latency, and a single-clock trip gives a single-clock cut.
- R6: The fault asserts on the clock `PROP_CYC`+1 after the first clock that samples `inv_oc_i`=1. For a PFC trip it asserts on clock `BLANK_CYC`+`PROP_CYC`+1 after the run starts.
- R7: While faulted, `flt_oe_o`=1, `flt_n_o`=0 and both shutdown outputs are 1. When released, `flt_oe_o`=0 and `flt_n_o`=1.
- R8: An inverter trip last sampled on clock N releases the fault on clock N+`PROP_CYC`+`CLR_CYC`, provided the supply stays qualified. Release never follows fewer than `CLR_CYC` clocks without `uv_fall_i`.
- R9: A new trip during the clearance count restarts the count. The release then follows `CLR_CYC` clocks after the new trip's delayed cause ends, not at the earlier release time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_oc_i | input | 1 | Inverter overcurrent flag |
| pfc_oc_i | input | 1 | PFC overcurrent flag (blanked) |
| uv_rise_i | input | 1 | Supply above upper threshold |
| uv_fall_i | input | 1 | Supply below lower threshold |
| flt_oe_o | output | 1 | Fault pin pull-down enable |
| flt_n_o | output | 1 | Fault pin level, active low |
| gate_off_o | output | 1 | Inverter gate shutdown |
| pfc_off_o | output | 1 | PFC switch shutdown |

## Verification
The hardest case to reach is a restart of the clearance count. The count only runs after a latched fault, a full propagation delay and part of the clearance period have all passed. The stimulus builds it from a single-clock inverter pulse. It waits until the count is halfway through, then injects a second single-clock pulse. It checks that the fault is still held at the original release clock, and that the release moves to the later, recomputed clock. The blanking edge is covered by a table of PFC pulse widths around `BLANK_CYC`, plus an interrupted run.

// File: rtl/pwr_fault_pkg.sv
package pwr_fault_pkg;
  // Trip paths that share one propagation stage each
  localparam int PATH_INV = 0;
  localparam int PATH_PFC = 1;
  localparam int NPATH    = 2;

  typedef logic [NPATH-1:0] path_vec_t;
endpackage

// File: rtl/pfs_blank.sv
// Consecutive-sample qualifier: output high once trip_i has been sampled
// high on CYC consecutive clocks, and for as long as it stays high.
module pfs_blank #(
  parameter int CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  output logic qual_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      qual_o <= 1'b0;
    end else begin
      if (!trip_i)
        run_q <= '0;
      else if (run_q != LAST)
        run_q <= run_q + 1'b1;
      qual_o <= trip_i && (run_q == LAST);
    end
  end
endmodule

// File: rtl/pfs_delay.sv
// Fixed-latency delay of a level by DEPTH clocks.
module pfs_delay #(
  parameter int DEPTH = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[DEPTH-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/pfs_hyst.sv
// Two-level supply qualifier: low flag dominates, neither flag holds state.
module pfs_hyst (
  input  logic clk,
  input  logic rst,
  input  logic above_i,
  input  logic below_i,
  output logic ok_o
);
  always_ff @(posedge clk) begin
    if (rst)          ok_o <= 1'b0;
    else if (below_i) ok_o <= 1'b0;
    else if (above_i) ok_o <= 1'b1;
  end
endmodule

// File: rtl/pfs_clear.sv
// Fault latch with restartable clearance countdown.
module pfs_clear #(
  parameter int CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause_i,
  output logic fault_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o <= 1'b1;
      cnt_q   <= '0;
    end else if (cause_i) begin
      fault_o <= 1'b1;
      cnt_q   <= '0;
    end else if (fault_o) begin
      if (cnt_q == LAST) begin
        fault_o <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_fault_sup.sv
module pwr_fault_sup
  import pwr_fault_pkg::*;
#(
  parameter int BLANK_CYC = 18,
  parameter int PROP_CYC  = 35,
  parameter int CLR_CYC   = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic inv_oc_i,
  input  logic pfc_oc_i,
  input  logic uv_rise_i,
  input  logic uv_fall_i,
  output logic flt_oe_o,
  output logic flt_n_o,
  output logic gate_off_o,
  output logic pfc_off_o
);
  logic      pfc_qual;
  logic      inv_q;
  logic      supply_ok;
  logic      faulted;
  path_vec_t acc;
  path_vec_t rep;

  pfs_blank #(.CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .trip_i(pfc_oc_i), .qual_o(pfc_qual)
  );

  pfs_hyst u_hyst (
    .clk(clk), .rst(rst), .above_i(uv_rise_i), .below_i(uv_fall_i), .ok_o(supply_ok)
  );

  assign acc[PATH_INV] = inv_oc_i;
  assign acc[PATH_PFC] = pfc_qual;

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      pfs_delay #(.DEPTH(PROP_CYC)) u_dly (
        .clk(clk), .rst(rst), .d_i(acc[g]), .q_o(rep[g])
      );
    end
  endgenerate

  pfs_clear #(.CYC(CLR_CYC)) u_clear (
    .clk(clk), .rst(rst), .cause_i((|rep) | ~supply_ok), .fault_o(faulted)
  );

  always_ff @(posedge clk) begin
    if (rst) inv_q <= 1'b0;
    else     inv_q <= inv_oc_i;
  end

  assign flt_oe_o   = faulted;
  assign flt_n_o    = ~faulted;
  assign gate_off_o = faulted | inv_q;
  assign pfc_off_o  = faulted | pfc_qual;
endmodule

// File: rtl/pwr_fault_sup_chk.sv
module pwr_fault_sup_chk #(
  parameter int BLANK_CYC = 18,
  parameter int CLR_CYC   = 100000
) (
  input logic clk,
  input logic rst,
  input logic inv_oc_i,
  input logic pfc_oc_i,
  input logic uv_fall_i,
  input logic flt_oe_o,
  input logic gate_off_o,
  input logic pfc_off_o
);
  localparam int RW = $clog2(BLANK_CYC + 1);
  localparam int QW = $clog2(CLR_CYC + 1);

  logic [RW-1:0] pfc_run;
  logic [QW-1:0] fall_quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      pfc_run    <= '0;
      fall_quiet <= '0;
    end else begin
      if (!pfc_oc_i) pfc_run <= '0;
      else if (pfc_run != RW'(BLANK_CYC)) pfc_run <= pfc_run + 1'b1;
      if (uv_fall_i) fall_quiet <= '0;
      else if (fall_quiet != QW'(CLR_CYC)) fall_quiet <= fall_quiet + 1'b1;
    end
  end

  AST_UV_TO_FAULT: assert property (@(posedge clk) disable iff (rst)
    uv_fall_i |-> ##2 flt_oe_o); // R2
  AST_PFC_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    ($rose(pfc_off_o) && !flt_oe_o) |-> (pfc_run == RW'(BLANK_CYC))); // R3
  AST_PFC_OFF_LIVE: assert property (@(posedge clk) disable iff (rst)
    (pfc_off_o && !flt_oe_o) |-> $past(pfc_oc_i)); // R4
  AST_INV_CUT: assert property (@(posedge clk) disable iff (rst)
    inv_oc_i |=> gate_off_o); // R5
  AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (rst)
    flt_oe_o |-> (gate_off_o && pfc_off_o)); // R7
  AST_CLR_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(flt_oe_o) |-> ($past(fall_quiet) == QW'(CLR_CYC))); // R8
endmodule

bind pwr_fault_sup pwr_fault_sup_chk #(
  .BLANK_CYC(BLANK_CYC),
  .CLR_CYC(CLR_CYC)
) u_chk (
  .clk(clk),
  .rst(rst),
  .inv_oc_i(inv_oc_i),
  .pfc_oc_i(pfc_oc_i),
  .uv_fall_i(uv_fall_i),
  .flt_oe_o(flt_oe_o),
  .gate_off_o(gate_off_o),
  .pfc_off_o(pfc_off_o)
);

// File: tb/pwr_fault_sup_tb.sv
module pwr_fault_sup_tb;
  localparam int B = 4;
  localparam int P = 6;
  localparam int C = 20;
  localparam int NVEC = 6;
  // {pulse length, fault expected}
  localparam int VEC [NVEC][2] = '{'{1,0}, '{2,0}, '{3,0}, '{4,1}, '{5,1}, '{9,1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inv_oc_i = 1'b0, pfc_oc_i = 1'b0, uv_rise_i = 1'b0, uv_fall_i = 1'b0;
  logic flt_oe_o, flt_n_o, gate_off_o, pfc_off_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_fault_sup #(.BLANK_CYC(B), .PROP_CYC(P), .CLR_CYC(C)) u_dut (
    .clk(clk), .rst(rst), .inv_oc_i(inv_oc_i), .pfc_oc_i(pfc_oc_i),
    .uv_rise_i(uv_rise_i), .uv_fall_i(uv_fall_i), .flt_oe_o(flt_oe_o),
    .flt_n_o(flt_n_o), .gate_off_o(gate_off_o), .pfc_off_o(pfc_off_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 flt_n", flt_n_o, 1'b0);
    chk("R1 oe", flt_oe_o, 1'b1);
    chk("R1 gate_off", gate_off_o, 1'b1);
    chk("R1 pfc_off", pfc_off_o, 1'b1);
    step(5);
    chk("R1 held without supply", flt_n_o, 1'b0);
    uv_rise_i = 1'b1;
    step(C);
    chk("R1 before release", flt_n_o, 1'b0);
    step(1);
    chk("R1 released", flt_n_o, 1'b1);
    chk("R7 oe released", flt_oe_o, 1'b0);
    chk("R7 gate released", gate_off_o, 1'b0);

    // R3 / R4 / R6: table of PFC pulse widths around the blanking limit
    for (int i = 0; i < NVEC; i++) begin
      pfc_oc_i = 1'b1;
      step(VEC[i][0]);
      chk("R4 pfc_off at run end", pfc_off_o, logic'(VEC[i][0] >= B));
      pfc_oc_i = 1'b0;
      step(P + 2);
      chk("R3 fault after pulse", flt_oe_o, logic'(VEC[i][1]));
      step(C + 2);
      chk("R8 idle after pulse", flt_n_o, 1'b1);
    end

    // R3 interrupted run is not accepted
    pfc_oc_i = 1'b1; step(B - 1);
    pfc_oc_i = 1'b0; step(1);
    pfc_oc_i = 1'b1; step(B - 1);
    chk("R3 split run pfc_off", pfc_off_o, 1'b0);
    pfc_oc_i = 1'b0; step(P + 3);
    chk("R3 split run no fault", flt_n_o, 1'b1);

    // R4 / R6 / R8 exact PFC timing
    pfc_oc_i = 1'b1;
    step(B - 1);
    chk("R4 pfc_off before accept", pfc_off_o, 1'b0);
    step(1);
    chk("R4 pfc_off on accept", pfc_off_o, 1'b1);
    chk("R4 gate unaffected", gate_off_o, 1'b0);
    step(P);
    chk("R6 pfc no fault yet", flt_n_o, 1'b1);
    step(1);
    chk("R6 pfc fault", flt_n_o, 1'b0);
    chk("R7 gate during fault", gate_off_o, 1'b1);
    pfc_oc_i = 1'b0;
    step(P + C);
    chk("R8 pfc still held", flt_n_o, 1'b0);
    step(1);
    chk("R8 pfc released", flt_n_o, 1'b1);
    step(3);

    // R5 / R6 / R8 exact inverter timing
    inv_oc_i = 1'b1;
    step(1);
    chk("R5 gate cut", gate_off_o, 1'b1);
    chk("R5 no fault yet", flt_n_o, 1'b1);
    step(P - 1);
    chk("R6 inv no fault yet", flt_n_o, 1'b1);
    step(1);
    chk("R6 inv fault", flt_n_o, 1'b0);
    chk("R7 oe on", flt_oe_o, 1'b1);
    chk("R7 pfc_off on", pfc_off_o, 1'b1);
    step(2);
    inv_oc_i = 1'b0;
    step(P + C - 1);
    chk("R8 inv still held", flt_n_o, 1'b0);
    step(1);
    chk("R8 inv released", flt_n_o, 1'b1);
    chk("R7 gate released", gate_off_o, 1'b0);
    step(3);

    // R5 single-clock cut, then R9 restart
    inv_oc_i = 1'b1;
    step(1);
    chk("R5 pulse cut", gate_off_o, 1'b1);
    inv_oc_i = 1'b0;
    step(1);
    chk("R5 pulse cut ends", gate_off_o, 1'b0);
    step(P - 1);
    chk("R6 pulse fault", flt_n_o, 1'b0);
    step(C / 2);
    inv_oc_i = 1'b1;
    step(1);
    inv_oc_i = 1'b0;
    step(C - C / 2 - 1);
    chk("R9 held at old release", flt_n_o, 1'b0);
    step(P + C / 2);
    chk("R9 held before new release", flt_n_o, 1'b0);
    step(1);
    chk("R9 new release", flt_n_o, 1'b1);
    step(3);

    // R2 supply hysteresis
    uv_rise_i = 1'b0;
    step(5);
    chk("R2 hold between thresholds", flt_n_o, 1'b1);
    uv_fall_i = 1'b1;
    step(1);
    chk("R2 one clock after low", flt_n_o, 1'b1);
    step(1);
    chk("R2 fault on low supply", flt_n_o, 1'b0);
    uv_fall_i = 1'b0;
    step(C + 5);
    chk("R2 stays lost between thresholds", flt_n_o, 1'b0);
    uv_rise_i = 1'b1;
    uv_fall_i = 1'b1;
    step(C + 3);
    chk("R2 low flag wins", flt_n_o, 1'b0);
    uv_fall_i = 1'b0;
    step(C);
    chk("R2 before requalify", flt_n_o, 1'b0);
    step(1);
    chk("R2 requalified", flt_n_o, 1'b1);

    finish_run();
  end
endmodule